// File: doc/BRIEF.md
# Receive Flow Descriptor Builder

This block turns the start of each received packet into descriptor control information. The start-of-packet beat of the incoming stream carries a flow index and the packet length. The block uses the flow index to read an entry from a flow table that software programs. From that entry it builds a descriptor request. The request gives the descriptor type, the data offset, two flags that say whether to keep the sideband data, the destination queue, and the free-descriptor queue that the buffer must come from.

Flows belong to no channel. Each packet names its own flow, so two packets in a row may use different entries. The entry is captured on the start-of-packet beat and stays in use until end-of-packet. A new descriptor request is made for the first buffer and for each further buffer that the stream asks for within the packet.

Each flow picks its free-descriptor queue in one of three ways: one fixed queue, a queue chosen by packet length, or a queue chosen by buffer position within the packet. Writing the memory and pushing or popping the queues happen outside this block.

Top module: `rx_flow_desc_builder`

## Requirements
- R1: After a synchronous active-low reset, `d_valid` is low, and it stays low until an accepted beat asks for a descriptor.
- R2: A beat with `s_valid` and `s_sop` high produces exactly one descriptor in the next cycle, with `d_first`=1. The fields come from the entry of flow `s_flow`. Control word (select 0) layout: [1:0] descriptor type (0 = host, any other value = non-host), [10:2] data offset, [11] keep protocol-specific info, [12] keep extended packet info, [14:13] free-queue mode, [16:15] destination qmgr, [28:17] destination qnum.
- R3: The flow is chosen separately for each packet. Back-to-back packets that name different flows each take their own entry.
- R4: The entry and the length are captured at start-of-packet and held until end-of-packet. Later `s_flow` values and table writes made during the packet do not change that packet's descriptors. A table write takes effect from the next packet on.
- R5: Mode 0 (single) and mode 3 always select free queue 0. Free queue k is held in word 1+k as [13:12] qmgr and [11:0] qnum.
- R6: Mode 1 (size) compares the packet length with thresholds T0, T1 and T2, held in words 5, 6 and 7 as [15:0]. It selects queue 0 if length <= T0, else queue 1 if length <= T1, else queue 2 if length <= T2, else queue 3.
- R7: Mode 2 (buffer number) on a host-type entry selects queue 0 for the first buffer, queue 1 for the second, queue 2 for the third, and queue 3 for every buffer after that.
- R8: Mode 2 on a non-host entry falls back to queue 0 and sets `d_mode_err` on every descriptor of that packet. In every other case `d_mode_err` is 0.
- R9: A mid-packet beat makes a descriptor (`d_first`=0) only when `s_newbuf` is high. A beat without `s_sop` while no packet is open produces nothing.
- R10: Both the destination queue and the free queue are reported as a 2-bit qmgr and a 12-bit qnum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Flow table write strobe |
| cfg_flow | input | 3 | Flow entry to write |
| cfg_sel | input | 3 | Word within the entry (0 control, 1-4 free queues, 5-7 thresholds) |
| cfg_wdata | input | 32 | Write data |
| s_valid | input | 1 | Stream beat valid |
| s_sop | input | 1 | Start-of-packet beat |
| s_eop | input | 1 | End-of-packet beat |
| s_newbuf | input | 1 | Mid-packet beat needs a new buffer |
| s_flow | input | 3 | Flow index, sampled on start-of-packet |
| s_len | input | 16 | Packet length, sampled on start-of-packet |
| d_valid | output | 1 | Descriptor request valid |
| d_first | output | 1 | Request is for the first buffer of a packet |
| d_type | output | 2 | Descriptor type |
| d_offset | output | 9 | Data offset |
| d_keep_ps | output | 1 | Keep protocol-specific info |
| d_keep_epib | output | 1 | Keep extended packet info |
| d_dest_qmgr | output | 2 | Destination queue manager |
| d_dest_qnum | output | 12 | Destination queue number |
| d_fdq_qmgr | output | 2 | Free queue manager |
| d_fdq_qnum | output | 12 | Free queue number |
| d_mode_err | output | 1 | Buffer-number mode was set on a non-host entry |

## Verification
The bench programs all eight flows so that they cover every mode with both host and non-host types. Each flow is then sent packets whose lengths sit exactly on and one above each threshold, with five buffers per packet. A comparison written with < instead of <= would pick the wrong queue at each threshold. A buffer counter that wraps instead of saturating would go back to queue 0 on the fifth buffer. A design that does not fall back to single mode would leave the error flag clear or pick the wrong queue on non-host entries. Other packets change `s_flow` and rewrite the table in the middle of a packet, and send beats outside any packet or without a new-buffer request. A builder that reads the table on every beat would show the new values too early, and one that ignores packet framing would issue stray descriptors.

// File: rtl/rxfd_pkg.sv
// Package: shared widths, field positions and the decoded flow entry type
// for the receive flow descriptor builder.
package rxfd_pkg;
    parameter int TYPE_W = 2;
    parameter int OFF_W  = 9;
    parameter int QMGR_W = 2;
    parameter int QNUM_W = 12;
    parameter int LEN_W  = 16;
    parameter int N_FDQ  = 4;
    parameter int N_THR  = N_FDQ - 1;
    parameter int WORD_W = 32;
    localparam int N_WORDS = 1 + N_FDQ + N_THR;
    localparam int SEL_W   = $clog2(N_WORDS);
    localparam int FSEL_W  = $clog2(N_FDQ);

    typedef enum logic [1:0] {
        FDQ_SINGLE = 2'd0,
        FDQ_BYSIZE = 2'd1,
        FDQ_BYBUF  = 2'd2,
        FDQ_SPARE  = 2'd3
    } fdq_mode_e;

    localparam logic [TYPE_W-1:0] TYPE_HOST = '0;

    typedef struct packed {
        logic [QMGR_W-1:0] qmgr;
        logic [QNUM_W-1:0] qnum;
    } qref_t;

    typedef struct packed {
        logic [TYPE_W-1:0]           dtype;
        logic [OFF_W-1:0]            offset;
        logic                        keep_ps;
        logic                        keep_epib;
        fdq_mode_e                   mode;
        qref_t                       dest;
        qref_t [N_FDQ-1:0]           fdq;
        logic  [N_THR-1:0][LEN_W-1:0] thr;
    } flow_entry_t;
endpackage

// File: rtl/rxfd_flow_table.sv
// Module: rxfd_flow_table
// Holds N_WORDS programmable words per flow and decodes the words of one
// flow, picked by rd_flow, into a flow_entry_t through a combinational path.
// Assumes that writes and reads of the same flow in one cycle may return
// the old value (the write lands at the clock edge).
module rxfd_flow_table
    import rxfd_pkg::*;
#(
    parameter int NUM_FLOWS = 8,
    localparam int FLOW_W = $clog2(NUM_FLOWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [FLOW_W-1:0] cfg_flow,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic [FLOW_W-1:0] rd_flow,
    output flow_entry_t       rd_entry
);
    logic [NUM_FLOWS-1:0][N_WORDS-1:0][WORD_W-1:0] words_q;
    logic [N_WORDS-1:0][WORD_W-1:0] sel_words;

    // One register bank per flow, cleared on reset and loaded on a matching write.
    for (genvar f = 0; f < NUM_FLOWS; f++) begin : g_flow
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words_q[f] <= '0;
            end else if (cfg_we && (cfg_flow == FLOW_W'(f))) begin
                words_q[f][cfg_sel] <= cfg_wdata;
            end
        end
    end

    // Decode the selected flow's words into entry fields.
    always_comb begin
        sel_words          = words_q[rd_flow];
        rd_entry.dtype     = sel_words[0][1:0];
        rd_entry.offset    = sel_words[0][10:2];
        rd_entry.keep_ps   = sel_words[0][11];
        rd_entry.keep_epib = sel_words[0][12];
        rd_entry.mode      = fdq_mode_e'(sel_words[0][14:13]);
        rd_entry.dest.qmgr = sel_words[0][16:15];
        rd_entry.dest.qnum = sel_words[0][28:17];
        for (int k = 0; k < N_FDQ; k++) begin
            rd_entry.fdq[k].qmgr = sel_words[1+k][13:12];
            rd_entry.fdq[k].qnum = sel_words[1+k][11:0];
        end
        for (int k = 0; k < N_THR; k++) begin
            rd_entry.thr[k] = sel_words[1+N_FDQ+k][LEN_W-1:0];
        end
    end

    // R2: a written control word is visible on the read port one cycle later.
    p_wr_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_we) && $past(cfg_sel) == '0 && $past(cfg_flow) == rd_flow)
        |-> (rd_entry.dest.qnum == $past(cfg_wdata[28:17])));
endmodule

// File: rtl/rxfd_fdq_select.sv
// Module: rxfd_fdq_select
// Picks the free-descriptor queue for one buffer from the flow's mode, the
// packet length and the buffer position. Purely combinational. Assumes the
// buffer index given is already saturated at N_FDQ-1.
module rxfd_fdq_select
    import rxfd_pkg::*;
(
    input  flow_entry_t       entry,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic [FSEL_W-1:0] buf_idx,
    output qref_t             fdq,
    output logic              mode_err
);
    logic [FSEL_W-1:0] size_idx;
    logic [FSEL_W-1:0] pick;

    // Size class: first threshold that the length does not exceed.
    always_comb begin
        size_idx = FSEL_W'(N_THR);
        for (int k = N_THR - 1; k >= 0; k--) begin
            if (pkt_len <= entry.thr[k]) size_idx = FSEL_W'(k);
        end
    end

    // Mode decode with fallback for buffer mode on non-host entries.
    always_comb begin
        pick     = '0;
        mode_err = 1'b0;
        unique case (entry.mode)
            FDQ_BYSIZE: pick = size_idx;
            FDQ_BYBUF: begin
                if (entry.dtype == TYPE_HOST) pick = buf_idx;
                else                          mode_err = 1'b1;
            end
            default: pick = '0;
        endcase
        fdq = entry.fdq[pick];
    end
endmodule

// File: rtl/rx_flow_desc_builder.sv
// Module: rx_flow_desc_builder (top)
// Captures the flow entry and length on start-of-packet and issues one
// registered descriptor request per buffer: the first on the start-of-packet
// beat, then one for each mid-packet beat with s_newbuf. Assumes each
// packet begins with s_sop. A new s_sop while a packet is open starts a new packet.
module rx_flow_desc_builder
    import rxfd_pkg::*;
#(
    parameter int NUM_FLOWS = 8,
    localparam int FLOW_W = $clog2(NUM_FLOWS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [FLOW_W-1:0]  cfg_flow,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [WORD_W-1:0]  cfg_wdata,
    input  logic               s_valid,
    input  logic               s_sop,
    input  logic               s_eop,
    input  logic               s_newbuf,
    input  logic [FLOW_W-1:0]  s_flow,
    input  logic [LEN_W-1:0]   s_len,
    output logic               d_valid,
    output logic               d_first,
    output logic [TYPE_W-1:0]  d_type,
    output logic [OFF_W-1:0]   d_offset,
    output logic               d_keep_ps,
    output logic               d_keep_epib,
    output logic [QMGR_W-1:0]  d_dest_qmgr,
    output logic [QNUM_W-1:0]  d_dest_qnum,
    output logic [QMGR_W-1:0]  d_fdq_qmgr,
    output logic [QNUM_W-1:0]  d_fdq_qnum,
    output logic               d_mode_err
);
    localparam logic [FSEL_W-1:0] IDX_MAX = FSEL_W'(N_FDQ - 1);

    flow_entry_t       tbl_entry, ctx_q, cur_entry;
    logic [LEN_W-1:0]  len_q, cur_len;
    logic [FSEL_W-1:0] bufcnt_q, cur_idx;
    logic              in_pkt_q;
    logic              sop_go, cont_go, fire;
    qref_t             sel_fdq;
    logic              sel_err;

    rxfd_flow_table #(.NUM_FLOWS(NUM_FLOWS)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_flow (cfg_flow),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .rd_flow  (s_flow),
        .rd_entry (tbl_entry)
    );

    // Beat qualification and choice between the live table and the captured context.
    always_comb begin
        sop_go    = s_valid && s_sop;
        cont_go   = s_valid && !s_sop && in_pkt_q && s_newbuf;
        fire      = sop_go || cont_go;
        cur_entry = sop_go ? tbl_entry : ctx_q;
        cur_len   = sop_go ? s_len : len_q;
        cur_idx   = sop_go ? '0 : bufcnt_q;
    end

    rxfd_fdq_select u_sel (
        .entry   (cur_entry),
        .pkt_len (cur_len),
        .buf_idx (cur_idx),
        .fdq     (sel_fdq),
        .mode_err(sel_err)
    );

    // Packet context: capture at start-of-packet, count buffers, close at end-of-packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pkt_q <= 1'b0;
            ctx_q    <= '0;
            len_q    <= '0;
            bufcnt_q <= '0;
        end else if (sop_go) begin
            ctx_q    <= tbl_entry;
            len_q    <= s_len;
            bufcnt_q <= FSEL_W'(1);
            in_pkt_q <= !s_eop;
        end else if (s_valid && in_pkt_q) begin
            if (s_newbuf && bufcnt_q != IDX_MAX) bufcnt_q <= bufcnt_q + 1'b1;
            if (s_eop) in_pkt_q <= 1'b0;
        end
    end

    // Descriptor output register: valid every cycle, fields only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_valid     <= 1'b0;
            d_first     <= 1'b0;
            d_type      <= '0;
            d_offset    <= '0;
            d_keep_ps   <= 1'b0;
            d_keep_epib <= 1'b0;
            d_dest_qmgr <= '0;
            d_dest_qnum <= '0;
            d_fdq_qmgr  <= '0;
            d_fdq_qnum  <= '0;
            d_mode_err  <= 1'b0;
        end else begin
            d_valid <= fire;
            if (fire) begin
                d_first     <= sop_go;
                d_type      <= cur_entry.dtype;
                d_offset    <= cur_entry.offset;
                d_keep_ps   <= cur_entry.keep_ps;
                d_keep_epib <= cur_entry.keep_epib;
                d_dest_qmgr <= cur_entry.dest.qmgr;
                d_dest_qnum <= cur_entry.dest.qnum;
                d_fdq_qmgr  <= sel_fdq.qmgr;
                d_fdq_qnum  <= sel_fdq.qnum;
                d_mode_err  <= sel_err;
            end
        end
    end

    // R2: a start-of-packet beat yields a first-buffer descriptor next cycle.
    p_sop_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_sop) |=> (d_valid && d_first));

    // R9: no accepted beat in the previous cycle means no descriptor now.
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(s_valid) |-> !d_valid);

    // R9: follow-on descriptors only come from an open packet.
    p_buf_in_pkt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && !d_first) |-> $past(in_pkt_q));

    // R8: the mode error is only reported for non-host descriptor types.
    p_err_nonhost_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && d_mode_err) |-> (d_type != TYPE_HOST));

    // R4: the destination stays the same across the buffers of one packet.
    p_dest_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && !d_first && $past(d_valid)) |-> (d_dest_qnum == $past(d_dest_qnum)));
endmodule

// File: tb/rx_flow_desc_builder_bench.sv
module rx_flow_desc_builder_bench;
    import rxfd_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int NF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_flow = '0, cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic s_valid = 1'b0, s_sop = 1'b0, s_eop = 1'b0, s_newbuf = 1'b0;
    logic [2:0] s_flow = '0;
    logic [15:0] s_len = '0;
    logic d_valid, d_first, d_keep_ps, d_keep_epib, d_mode_err;
    logic [1:0] d_type, d_dest_qmgr, d_fdq_qmgr;
    logic [8:0] d_offset;
    logic [11:0] d_dest_qnum, d_fdq_qnum;

    int n_tests = 0, n_fail = 0;
    logic [31:0] sh_w [NF][8];
    logic [31:0] lat_w [8];
    logic [15:0] lat_len;
    int lat_idx = 0;
    bit in_pkt = 0;

    rx_flow_desc_builder u_rx_flow_desc_builder (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_flow(cfg_flow),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .s_valid(s_valid),
        .s_sop(s_sop), .s_eop(s_eop), .s_newbuf(s_newbuf), .s_flow(s_flow),
        .s_len(s_len), .d_valid(d_valid), .d_first(d_first), .d_type(d_type),
        .d_offset(d_offset), .d_keep_ps(d_keep_ps), .d_keep_epib(d_keep_epib),
        .d_dest_qmgr(d_dest_qmgr), .d_dest_qnum(d_dest_qnum),
        .d_fdq_qmgr(d_fdq_qmgr), .d_fdq_qnum(d_fdq_qnum), .d_mode_err(d_mode_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run hung, actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int f, input int sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_flow = 3'(f); cfg_sel = 3'(sel); cfg_wdata = data;
        sh_w[f][sel] = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic prog_flow(input int f, input int typ, input int mode);
        logic [31:0] c;
        c = '0;
        c[1:0] = 2'(typ); c[10:2] = 9'(f * 37 + 5);
        c[11] = f[0]; c[12] = f[1]; c[14:13] = 2'(mode);
        c[16:15] = 2'(f + 1); c[28:17] = 12'(f * 300 + 11);
        wr(f, 0, c);
        for (int k = 0; k < 4; k++) wr(f, 1 + k, {18'd0, 2'(k), 12'(f * 16 + k + 100)});
        for (int k = 0; k < 3; k++) wr(f, 5 + k, {16'd0, 16'(100 * (k + 1) + f)});
    endtask

    function automatic logic [63:0] pack_out();
        return {15'd0, d_valid, d_first, d_type, d_offset, d_keep_ps, d_keep_epib,
                d_dest_qmgr, d_dest_qnum, d_fdq_qmgr, d_fdq_qnum, d_mode_err};
    endfunction

    // Reference model: expected descriptor from the latched words.
    function automatic logic [63:0] expect_desc(input bit first);
        int mode, typ, pick; bit err;
        logic [31:0] fq;
        mode = int'(lat_w[0][14:13]); typ = int'(lat_w[0][1:0]); pick = 0; err = 0;
        if (mode == 1) begin
            if (lat_len <= lat_w[5][15:0]) pick = 0;
            else if (lat_len <= lat_w[6][15:0]) pick = 1;
            else if (lat_len <= lat_w[7][15:0]) pick = 2;
            else pick = 3;
        end else if (mode == 2) begin
            if (typ == 0) pick = (lat_idx > 3) ? 3 : lat_idx;
            else err = 1;
        end
        fq = lat_w[1 + pick];
        return {15'd0, 1'b1, first, lat_w[0][1:0], lat_w[0][10:2], lat_w[0][11],
                lat_w[0][12], lat_w[0][16:15], lat_w[0][28:17], fq[13:12], fq[11:0], err};
    endfunction

    task automatic beat(input string req, input bit sop, input bit eop, input bit nb,
                        input int f, input int len);
        logic [63:0] exp; bit out;
        @(negedge clk);
        s_valid = 1; s_sop = sop; s_eop = eop; s_newbuf = nb;
        s_flow = 3'(f); s_len = 16'(len);
        out = 0;
        if (sop) begin
            for (int k = 0; k < 8; k++) lat_w[k] = sh_w[f][k];
            lat_len = 16'(len); lat_idx = 0; in_pkt = 1; out = 1;
        end else if (in_pkt && nb) out = 1;
        exp = out ? expect_desc(sop) : 64'd0;
        if (out && !sop) ;
        @(negedge clk);
        s_valid = 0;
        if (out) check(req, pack_out(), exp);
        else check(req, {63'd0, d_valid}, 64'd0);
        if (out) lat_idx++;
        if (in_pkt && eop) in_pkt = 0;
    endtask

    task automatic packet(input string req, input int f, input int len, input int nbufs);
        beat(req, 1, nbufs == 1, 0, f, len);
        for (int b = 1; b < nbufs; b++) beat(req, 0, b == nbufs - 1, 1, f, len);
    endtask

    initial begin
        for (int f = 0; f < NF; f++) for (int k = 0; k < 8; k++) sh_w[f][k] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {63'd0, d_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {63'd0, d_valid}, 64'd0);

        // Flows 2*mode+type: every mode with host (0) and non-host (1) type.
        for (int m = 0; m < 4; m++)
            for (int t = 0; t < 2; t++) prog_flow(2 * m + t, t, m);

        // R2 R5 R6 R7 R8 R10: sweep flows, threshold boundary lengths, 5 buffers.
        for (int f = 0; f < NF; f++) begin
            int lens [8];
            lens[0] = 0; lens[7] = 65535;
            for (int k = 0; k < 3; k++) begin
                lens[1 + 2*k] = 100 * (k + 1) + f;
                lens[2 + 2*k] = 100 * (k + 1) + f + 1;
            end
            for (int li = 0; li < 8; li++) packet("R2_R5_R6_R7_R8_R10", f, lens[li], 5);
        end

        // R3: back-to-back single-beat packets on changing flows.
        for (int i = 0; i < 16; i++) packet("R3", (i * 5) % NF, 150 + i, 1);

        // R9: beats outside a packet, and mid-packet beats without newbuf.
        beat("R9", 0, 0, 1, 3, 10);
        beat("R9", 0, 1, 1, 3, 10);
        beat("R9", 1, 0, 0, 4, 250);
        beat("R9", 0, 0, 0, 4, 250);
        beat("R9", 0, 0, 1, 4, 250);
        beat("R9", 0, 1, 0, 4, 250);
        beat("R9", 0, 0, 1, 4, 250);

        // R4: s_flow changes mid-packet and a table write mid-packet are ignored.
        beat("R4", 1, 0, 0, 2, 120);
        beat("R4", 0, 0, 1, 6, 999);
        begin
            logic [31:0] saved [8];
            for (int k = 0; k < 8; k++) saved[k] = lat_w[k];
            wr(2, 0, {3'd0, 12'd4000, 2'd3, 2'd2, 1'b1, 1'b1, 9'd77, 2'd0});
            wr(2, 3, {18'd0, 2'd1, 12'd2222});
            for (int k = 0; k < 8; k++) lat_w[k] = saved[k];
        end
        beat("R4", 0, 0, 1, 2, 120);
        beat("R4", 0, 1, 1, 2, 120);
        packet("R4", 2, 120, 4);

        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule